// File: doc/BRIEF.md
# Same-As Recurrence Parallel Adder

This block adds two unsigned operands of `WIDTH` bits without an explicit carry chain. For each bit position it forms an intermediate value `q`, which stands for the carry into that bit. When the operand bits one position lower agree, `q` is forced to that shared bit. When they disagree, `q` copies the `q` of the position below. The value below bit 0 is fixed at zero. Each sum bit is then `q` when the two operand bits at that position agree, and the inverse of `q` when they differ.

Every position decides on its own whether it forces or copies. The resulting chain of "same as below" choices is therefore resolved by a logarithmic prefix network of (force, value) pairs. Each merge step needs no more than a two-input OR and a two-to-one multiplexer.

A parameter selects between two variants. In the flat variant the whole network sits in front of one output register, giving a latency of one cycle. In the split variant a register stage cuts the network halfway through its levels, giving a latency of two cycles. Operands are accepted with a valid strobe on every cycle, and each result appears with its own valid strobe. The `q` of the position just above the top bit is brought out as a carry.

Top module: `sarp_adder`

## Requirements
- R1: When bits n-1 of the two operands are equal, the resolved q_n (observable as sum[n] ^ a[n] ^ b[n]) equals that operand bit.
- R2: When bits n-1 of the two operands differ, q_n equals q_(n-1).
- R3: q_0 is zero, so sum[0] equals a[0] ^ b[0].
- R4: sum[n] is q_n when a[n] equals b[n] and ~q_n otherwise, which makes sum equal (a + b) modulo 2^WIDTH.
- R5: carry_out equals q_WIDTH, which is bit WIDTH of the full sum a + b.
- R6: out_valid rises exactly LAT cycles after in_valid, where LAT is 2 when PIPELINED is 1 and 1 when it is 0.
- R7: A synchronous active-high reset clears out_valid, sum and carry_out at the next clock edge and discards operands already inside the pipeline.
- R8: Operands presented on consecutive cycles produce results on consecutive cycles, one per cycle, each matched to its own operands.
- R9: Cycles with in_valid low leave sum and carry_out holding the last delivered result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on op_a/op_b are valid this cycle |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| out_valid | output | 1 | sum and carry_out carry a new result |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| carry_out | output | 1 | Carry above the top bit |

## Verification
In the split variant, the most demanding overlap is a new operand pair entering the first stage on the same edge that the previous pair's result leaves the output register. A reset can also arrive while both stages hold live data. Back-to-back random streams and gapped streams provoke the first case, and each result is judged against the bench's own sum of the operands driven LAT cycles earlier. A reset asserted in the middle of a stream provokes the second case, and it is judged by out_valid staying low until fresh operands have had time to travel through both stages.

// File: rtl/sarp_pkg.sv
package sarp_pkg;

  // One span of the same-as chain: whether it forces q, and the value it yields
  typedef struct packed {
    logic force_q;
    logic val;
  } span_t;

  // Merge an upper span over a lower one: a forcing upper span wins,
  // a copying upper span passes the lower result through.
  function automatic span_t merge(input span_t hi, input span_t lo);
    span_t r;
    r.force_q = hi.force_q | lo.force_q;
    r.val     = hi.force_q ? hi.val : lo.val;
    return r;
  endfunction

  function automatic int latency(input bit pipelined);
    return pipelined ? 2 : 1;
  endfunction

endpackage

// File: rtl/sarp_leaf.sv
module sarp_leaf #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH:0]   f_leaf,
  output logic [WIDTH:0]   v_leaf,
  output logic [WIDTH-1:0] differ
);
  // Node 0 is the fixed boundary below bit 0: forced to zero
  assign f_leaf[0] = 1'b1;
  assign v_leaf[0] = 1'b0;

  for (genvar i = 1; i <= WIDTH; i++) begin : g_leaf
    assign f_leaf[i] = ~(op_a[i-1] ^ op_b[i-1]);
    assign v_leaf[i] = op_a[i-1];
  end

  assign differ = op_a ^ op_b;
endmodule

// File: rtl/sarp_prefix_span.sv
module sarp_prefix_span #(
  parameter int NODES = 33,
  parameter int FIRST = 0,
  parameter int LAST  = 6
) (
  input  logic [NODES-1:0] f_in,
  input  logic [NODES-1:0] v_in,
  output logic [NODES-1:0] f_out,
  output logic [NODES-1:0] v_out
);
  import sarp_pkg::*;

  localparam int NL = LAST - FIRST;

  logic [NODES-1:0] f_lv [0:NL];
  logic [NODES-1:0] v_lv [0:NL];

  assign f_lv[0] = f_in;
  assign v_lv[0] = v_in;

  for (genvar l = 0; l < NL; l++) begin : g_lvl
    localparam int DIST = 1 << (FIRST + l);
    for (genvar i = 0; i < NODES; i++) begin : g_node
      if (i >= DIST) begin : g_cmb
        span_t hi, lo, res;
        assign hi  = '{force_q: f_lv[l][i],      val: v_lv[l][i]};
        assign lo  = '{force_q: f_lv[l][i-DIST], val: v_lv[l][i-DIST]};
        assign res = merge(hi, lo);
        assign f_lv[l+1][i] = res.force_q;
        assign v_lv[l+1][i] = res.val;
      end else begin : g_pass
        assign f_lv[l+1][i] = f_lv[l][i];
        assign v_lv[l+1][i] = v_lv[l][i];
      end
    end
  end

  assign f_out = f_lv[NL];
  assign v_out = v_lv[NL];
endmodule

// File: rtl/sarp_sum.sv
module sarp_sum #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] differ,
  input  logic [WIDTH:0]   q,
  output logic [WIDTH-1:0] sum_bits,
  output logic             carry_bit
);
  assign sum_bits  = differ ^ q[WIDTH-1:0];
  assign carry_bit = q[WIDTH];
endmodule

// File: rtl/sarp_adder.sv
module sarp_adder #(
  parameter int WIDTH     = 32,
  parameter bit PIPELINED = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             out_valid,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  localparam int NODES  = WIDTH + 1;
  localparam int LEVELS = $clog2(NODES);
  localparam int SPLIT  = PIPELINED ? LEVELS / 2 : LEVELS;
  localparam int LAT    = sarp_pkg::latency(PIPELINED);

  logic [NODES-1:0] f0, v0, f1, v1, f_r, v_r, f2, v2;
  logic [WIDTH-1:0] px0, px_r, sum_nx;
  logic             cy_nx, vld_s;

  sarp_leaf #(.WIDTH(WIDTH)) u_leaf (
    .op_a(op_a), .op_b(op_b), .f_leaf(f0), .v_leaf(v0), .differ(px0)
  );

  sarp_prefix_span #(.NODES(NODES), .FIRST(0), .LAST(SPLIT)) u_lower (
    .f_in(f0), .v_in(v0), .f_out(f1), .v_out(v1)
  );

  if (PIPELINED) begin : g_pipe
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_s <= 1'b0;
        f_r   <= '0;
        v_r   <= '0;
        px_r  <= '0;
      end else begin
        vld_s <= in_valid;
        f_r   <= f1;
        v_r   <= v1;
        px_r  <= px0;
      end
    end
  end else begin : g_flat
    assign vld_s = in_valid;
    assign f_r   = f1;
    assign v_r   = v1;
    assign px_r  = px0;
  end

  sarp_prefix_span #(.NODES(NODES), .FIRST(SPLIT), .LAST(LEVELS)) u_upper (
    .f_in(f_r), .v_in(v_r), .f_out(f2), .v_out(v2)
  );

  sarp_sum #(.WIDTH(WIDTH)) u_sum (
    .differ(px_r), .q(v2), .sum_bits(sum_nx), .carry_bit(cy_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      sum       <= '0;
      carry_out <= 1'b0;
    end else begin
      out_valid <= vld_s;
      if (vld_s) begin
        sum       <= sum_nx;
        carry_out <= cy_nx;
      end
    end
  end

  // R1 R2: the boundary node forces, so every resolved position is forced
  resolve_all_chk: assert property (@(posedge clk) disable iff (rst)
    vld_s |-> (&f2));

  // R3
  bit0_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (sum[0] == ($past(op_a[0], LAT) ^ $past(op_b[0], LAT))));

  // R4
  sum_value_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (sum == WIDTH'($past(op_a, LAT) + $past(op_b, LAT))));

  // R5
  carry_value_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({carry_out, sum} ==
                   ({1'b0, $past(op_a, LAT)} + {1'b0, $past(op_b, LAT)})));

  // R6
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, LAT));

  // R7
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && sum == '0 && !carry_out));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_s |=> ($stable(sum) && $stable(carry_out)));

endmodule

// File: tb/sarp_adder_test.sv
module sarp_adder_test;
  localparam int WIDTH = 32;
  localparam bit PIPE  = 1'b1;
  localparam int LAT   = PIPE ? 2 : 1;
  localparam int MAXN  = 64;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [WIDTH-1:0] op_a = '0;
  logic [WIDTH-1:0] op_b = '0;
  logic             out_valid;
  logic [WIDTH-1:0] sum;
  logic             carry_out;

  int n_checks = 0;
  int n_fail   = 0;

  logic [WIDTH-1:0] ea [0:MAXN-1];
  logic [WIDTH-1:0] eb [0:MAXN-1];
  logic             ev [0:MAXN-1];
  logic [WIDTH-1:0] last_sum;
  logic             last_cy;

  always #2.5 clk = ~clk;

  sarp_adder #(.WIDTH(WIDTH), .PIPELINED(PIPE)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .sum(sum), .carry_out(carry_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Full result check for operands a, b against the outputs now visible
  task automatic check_result(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    logic [WIDTH:0] full;
    logic [WIDTH:0] q;
    logic           r1_ok, r2_ok;
    full = {1'b0, a} + {1'b0, b};
    check("R4 sum", 64'(sum), 64'(full[WIDTH-1:0]));
    check("R5 carry_out", 64'(carry_out), 64'(full[WIDTH]));
    check("R3 bit0", 64'(sum[0]), 64'(a[0] ^ b[0]));
    for (int n = 0; n < WIDTH; n++) q[n] = sum[n] ^ a[n] ^ b[n];
    q[WIDTH] = carry_out;
    r1_ok = 1'b1;
    r2_ok = 1'b1;
    for (int n = 1; n <= WIDTH; n++) begin
      if (a[n-1] == b[n-1]) begin
        if (q[n] !== a[n-1]) r1_ok = 1'b0;
      end else begin
        if (q[n] !== q[n-1]) r2_ok = 1'b0;
      end
    end
    check("R1 forced q", 64'(r1_ok), 64'(1));
    check("R2 copied q", 64'(r2_ok), 64'(1));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R7 reset out_valid", 64'(out_valid), 64'(0));
    check("R7 reset sum", 64'(sum), 64'(0));
    check("R7 reset carry", 64'(carry_out), 64'(0));
    rst = 1'b0;
    last_sum = '0;
    last_cy  = 1'b0;
  endtask

  // Drive n entries from ea/eb/ev, one per cycle, and check each at its slot
  task automatic run_stream(input int n);
    for (int k = 0; k < n + LAT; k++) begin
      @(negedge clk);
      if (k >= LAT) begin
        check("R6 R8 out_valid", 64'(out_valid), 64'(ev[k-LAT]));
        if (ev[k-LAT]) begin
          check_result(ea[k-LAT], eb[k-LAT]);
          last_sum = sum;
          last_cy  = carry_out;
        end else begin
          check("R9 hold sum", 64'(sum), 64'(last_sum));
          check("R9 hold carry", 64'(carry_out), 64'(last_cy));
        end
      end
      if (k < n) begin
        in_valid = ev[k];
        op_a = ea[k];
        op_b = eb[k];
      end else begin
        in_valid = 1'b0;
        op_a = '0;
        op_b = '0;
      end
    end
  endtask

  task automatic test_patterns();
    ea[0] = '0;                 eb[0] = '0;
    ea[1] = '1;                 eb[1] = WIDTH'(1);
    ea[2] = '1;                 eb[2] = '1;
    ea[3] = {WIDTH/2{2'b10}};   eb[3] = {WIDTH/2{2'b01}};
    ea[4] = {WIDTH/2{2'b01}};   eb[4] = {WIDTH/2{2'b01}};
    ea[5] = {WIDTH/2{2'b10}};   eb[5] = {WIDTH/2{2'b10}};
    ea[6] = {1'b0, {WIDTH-1{1'b1}}}; eb[6] = WIDTH'(1);
    ea[7] = {1'b1, {WIDTH-1{1'b0}}}; eb[7] = {1'b1, {WIDTH-1{1'b0}}};
    for (int i = 0; i < 8; i++) ev[i] = 1'b1;
    run_stream(8);
  endtask

  task automatic test_random_burst();
    for (int i = 0; i < 40; i++) begin
      ea[i] = WIDTH'($urandom);
      eb[i] = WIDTH'($urandom);
      ev[i] = 1'b1;
    end
    run_stream(40);
  endtask

  task automatic test_gapped();
    for (int i = 0; i < 40; i++) begin
      ea[i] = WIDTH'($urandom);
      eb[i] = WIDTH'($urandom);
      ev[i] = (i % 3 != 1);
    end
    run_stream(40);
  endtask

  task automatic test_mid_reset();
    @(negedge clk);
    in_valid = 1'b1;
    op_a = '1;
    op_b = '1;
    @(negedge clk);
    op_a = WIDTH'(5);
    rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 mid reset out_valid", 64'(out_valid), 64'(0));
    check("R7 mid reset sum", 64'(sum), 64'(0));
    rst = 1'b0;
    for (int k = 0; k < LAT + 1; k++) begin
      @(negedge clk);
      check("R7 flushed out_valid", 64'(out_valid), 64'(0));
    end
    last_sum = '0;
    last_cy  = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    do_reset();
    test_patterns();
    test_random_burst();
    test_gapped();
    test_mid_reset();
    test_random_burst();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule